// File: doc/BRIEF.md
# Vector Lane Transpose-Interleave Unit

This block rearranges the elements of two source vectors in one registered operation. Each request carries two vectors, a permutation select and an element-size select. The unit pairs lanes from the two sources into alternating destination slots. It supports four permutations: transpose-even, transpose-odd, interleave-low and interleave-high. The element size can be 16, 32 or 64 bits across a 128-bit vector by default.

Small matrices are often held one row per register. Such a matrix can be transposed by chaining passes of this unit at growing element sizes, so no memory round trip is needed. For example, two interleave passes at the element size and then two more at twice that size turn four rows into four columns.

Requests are taken with a valid/ready handshake. The result appears in an output register one cycle after a request is accepted. It is held there until the downstream side takes it.

Top module: `vtx_permute_unit`

## Requirements
- R1: With `op_sel`=0 (transpose-even), destination lane 2i holds lane 2i of `src_a`, and destination lane 2i+1 holds lane 2i of `src_b`.
- R2: With `op_sel`=1 (transpose-odd), destination lane 2i holds lane 2i+1 of `src_a`, and destination lane 2i+1 holds lane 2i+1 of `src_b`.
- R3: With `op_sel`=2 (interleave-low), destination lane 2i holds lane i of `src_a`, and destination lane 2i+1 holds lane i of `src_b`, for i below half the lane count.
- R4: With `op_sel`=3 (interleave-high), destination lanes 2i and 2i+1 hold lane N/2+i of `src_a` and of `src_b` respectively, where N is the lane count.
- R5: `size_sel` 0, 1 and 2 select 16-, 32- and 64-bit lanes. The lane count is the vector width divided by the lane size. Lane 0 sits at the least significant bits. A legal request returns `out_err`=0.
- R6: An accepted request with `size_sel`=3 (an illegal code) raises `out_valid` with `out_err`=1 and leaves `out_data` unchanged.
- R7: The result is valid in the cycle after the request is accepted. `in_ready` is high whenever no result is waiting or the waiting result is being taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_err` hold their values.
- R9: During and just after reset, `out_valid`, `out_err` and `out_data` are all zero.
- R10: Four 32-bit-lane rows a, b, c, d are turned into the columns [a0 b0 c0 d0] through [a3 b3 c3 d3] in two stages. The first stage applies interleave-low and interleave-high at 32 bits to the pairs (a, b) and (c, d). The second stage applies interleave-low and interleave-high at 64 bits to the stage-one results.
- R11: A transpose-even pass and a transpose-odd pass on the same two sources together transpose every 2x2 block held across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| src_a | input | VEC_W | First source vector |
| src_b | input | VEC_W | Second source vector |
| op_sel | input | 2 | 0 transpose-even, 1 transpose-odd, 2 interleave-low, 3 interleave-high |
| size_sel | input | SIZE_W | 0: 16-bit, 1: 32-bit, 2: 64-bit lanes; other codes illegal |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | VEC_W | Permuted vector |
| out_err | output | 1 | Last accepted request had an illegal size code |

## Verification
Suppose the lane-select logic picks a wrong source or index for some size. The fault would show as misplaced lanes in `out_data` one cycle after the request is accepted. The fault may only appear for one size and one permutation, so every permutation is checked at every size. A bad handshake or holding register shows up differently. It would appear as a result that changes, vanishes or is duplicated while the output is stalled. Random stalls on the output therefore compare every held cycle against the first. An error path that corrupts the data register is caught by the next check that relies on the old data. That check comes right after the illegal request, and it also comes when the next legal result is compared.

// File: rtl/vtx_pkg.sv
package vtx_pkg;

  typedef enum logic [1:0] {
    OP_TRN_EVEN = 2'd0,
    OP_TRN_ODD  = 2'd1,
    OP_ZIP_LO   = 2'd2,
    OP_ZIP_HI   = 2'd3
  } vtx_op_e;

  localparam int OP_W = 2;

endpackage

// File: rtl/vtx_lane_perm.sv
module vtx_lane_perm
  import vtx_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int EW    = 16
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  vtx_op_e          op,
  output logic [VEC_W-1:0] res
);
  localparam int N    = VEC_W / EW;
  localparam int HALF = N / 2;

  for (genvar p = 0; p < HALF; p++) begin : g_pair
    logic [EW-1:0] slot_lo;
    logic [EW-1:0] slot_hi;

    always_comb begin
      unique case (op)
        OP_TRN_EVEN: begin
          slot_lo = src_a[(2*p)*EW +: EW];
          slot_hi = src_b[(2*p)*EW +: EW];
        end
        OP_TRN_ODD: begin
          slot_lo = src_a[(2*p+1)*EW +: EW];
          slot_hi = src_b[(2*p+1)*EW +: EW];
        end
        OP_ZIP_LO: begin
          slot_lo = src_a[p*EW +: EW];
          slot_hi = src_b[p*EW +: EW];
        end
        default: begin
          slot_lo = src_a[(HALF+p)*EW +: EW];
          slot_hi = src_b[(HALF+p)*EW +: EW];
        end
      endcase
    end

    assign res[(2*p)*EW +: EW]   = slot_lo;
    assign res[(2*p+1)*EW +: EW] = slot_hi;
  end

endmodule

// File: rtl/vtx_size_select.sv
module vtx_size_select #(
  parameter int VEC_W     = 128,
  parameter int NUM_SIZES = 3,
  parameter int SIZE_W    = 2
) (
  input  logic [NUM_SIZES-1:0][VEC_W-1:0] cand,
  input  logic [SIZE_W-1:0]               size_code,
  output logic [VEC_W-1:0]                res,
  output logic                            illegal
);

  always_comb begin
    res = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (int'(size_code) == k) res = cand[k];
    end
  end

  assign illegal = (int'(size_code) >= NUM_SIZES);

endmodule

// File: rtl/vtx_out_stage.sv
module vtx_out_stage #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             err_in,
  input  logic [VEC_W-1:0] data_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data,
  output logic             out_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_err   <= err_in;
      if (!err_in) out_data <= data_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vtx_permute_unit.sv
module vtx_permute_unit
  import vtx_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int MIN_EW    = 16,
  parameter int NUM_SIZES = 3,
  parameter int SIZE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [SIZE_W-1:0] size_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data,
  output logic              out_err
);

  logic [NUM_SIZES-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0]                chosen;
  logic                            bad_size;
  logic                            accept;
  vtx_op_e                         op;

  assign op = vtx_op_e'(op_sel);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    vtx_lane_perm #(
      .VEC_W (VEC_W),
      .EW    (MIN_EW << k)
    ) u_perm (
      .src_a (src_a),
      .src_b (src_b),
      .op    (op),
      .res   (cand[k])
    );
  end

  vtx_size_select #(
    .VEC_W     (VEC_W),
    .NUM_SIZES (NUM_SIZES),
    .SIZE_W    (SIZE_W)
  ) u_sel (
    .cand      (cand),
    .size_code (size_sel),
    .res       (chosen),
    .illegal   (bad_size)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vtx_out_stage #(
    .VEC_W (VEC_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .err_in    (bad_size),
    .data_in   (chosen),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_err   (out_err)
  );

endmodule

// File: rtl/vtx_permute_unit_chk.sv
module vtx_permute_unit_chk #(
  parameter int VEC_W     = 128,
  parameter int MIN_EW    = 16,
  parameter int NUM_SIZES = 3,
  parameter int SIZE_W    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [VEC_W-1:0]  src_a,
  input logic [1:0]        op_sel,
  input logic [SIZE_W-1:0] size_sel,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_data,
  input logic              out_err
);
  logic rst_q;
  logic take;
  logic legal;

  always_ff @(posedge clk) rst_q <= rst;

  assign take  = in_valid && in_ready;
  assign legal = int'(size_sel) < NUM_SIZES;

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!out_valid && !out_err && out_data == '0));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  assert_bad_size_R6: assert property (@(posedge clk) disable iff (rst)
    (take && !legal) |=> (out_err && $stable(out_data)));

  assert_good_size_R5: assert property (@(posedge clk) disable iff (rst)
    (take && legal) |=> !out_err);

  assert_lane0_R1: assert property (@(posedge clk) disable iff (rst)
    (take && legal && (op_sel == 2'd0 || op_sel == 2'd2))
      |=> (out_data[MIN_EW-1:0] == $past(src_a[MIN_EW-1:0])));

endmodule

bind vtx_permute_unit vtx_permute_unit_chk #(
  .VEC_W     (VEC_W),
  .MIN_EW    (MIN_EW),
  .NUM_SIZES (NUM_SIZES),
  .SIZE_W    (SIZE_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .src_a     (src_a),
  .op_sel    (op_sel),
  .size_sel  (size_sel),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/test_vtx_permute_unit.sv
`timescale 1ns/1ps
module test_vtx_permute_unit;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic [1:0]    op_sel = '0;
  logic [1:0]    size_sel = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_data;
  logic          out_err;

  int checks = 0;
  int failures = 0;
  bit stall_mode = 0;

  logic [VW-1:0] exp_data_q[$];
  logic          exp_err_q[$];
  string         exp_tag_q[$];
  logic [VW-1:0] model_last = '0;
  logic [VW-1:0] last_out = '0;

  always #2.5 clk = ~clk;

  vtx_permute_unit i_vtx_permute_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .op_sel(op_sel), .size_sel(size_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err(out_err));

  function automatic logic [VW-1:0] ref_perm(logic [VW-1:0] a, logic [VW-1:0] b,
                                             int op, int sz);
    logic [VW-1:0] r;
    int ew, n, idx;
    ew = 16 << sz;
    n  = VW / ew;
    r  = '0;
    for (int j = 0; j < n; j++) begin
      case (op)
        0: idx = 2 * (j / 2);
        1: idx = 2 * (j / 2) + 1;
        2: idx = j / 2;
        default: idx = n / 2 + j / 2;
      endcase
      for (int t = 0; t < ew; t++)
        r[j*ew + t] = (j % 2 == 1) ? b[idx*ew + t] : a[idx*ew + t];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [VW-1:0] a, logic [VW-1:0] b, int op, int sz, string tag);
    @(posedge clk); #1;
    src_a = a; src_b = b; op_sel = 2'(op); size_sel = 2'(sz); in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    if (sz < 3) begin
      model_last = ref_perm(a, b, op, sz);
      exp_err_q.push_back(1'b0);
    end else begin
      exp_err_q.push_back(1'b1);
    end
    exp_data_q.push_back(model_last);
    exp_tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R7 valid one cycle after accept", {127'b0, out_valid}, 1);
  endtask

  task automatic run_op(logic [VW-1:0] a, logic [VW-1:0] b, int op, int sz,
                        string tag, output logic [VW-1:0] res);
    send(a, b, op, sz, tag);
    while (exp_data_q.size() != 0) @(negedge clk);
    @(posedge clk);
    res = last_out;
  endtask

  // monitor / scoreboard
  logic [VW-1:0] held_data;
  logic          held_err;
  bit            held_pending = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (held_pending && out_valid)
          check(out_data === held_data && out_err === held_err,
                "R8 output held during stall", out_data, held_data);
        held_pending = out_valid && !out_ready;
        held_data = out_data;
        held_err = out_err;
        if (out_valid && out_ready) begin
          if (exp_data_q.size() == 0) begin
            check(0, "R7 unexpected result", out_data, '0);
          end else begin
            logic [VW-1:0] ed;
            logic ee;
            string tg;
            ed = exp_data_q.pop_front();
            ee = exp_err_q.pop_front();
            tg = exp_tag_q.pop_front();
            check(out_data === ed, tg, out_data, ed);
            check(out_err === ee, {tg, " err flag"}, {127'b0, out_err}, {127'b0, ee});
            last_out = out_data;
          end
        end
      end
    end
  end

  // output back-pressure driver
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_mode ? ($urandom() % 3 != 0) : 1'b1;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [VW-1:0] ra, rb, rc, rd, t0, t1, t2, t3, c0, c1, c2, c3, ev, od;
    string nm[4];
    nm[0] = "R1 transpose-even"; nm[1] = "R2 transpose-odd";
    nm[2] = "R3 interleave-low"; nm[3] = "R4 interleave-high";

    // R9 reset state
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R9 reset out_valid", {127'b0, out_valid}, 0);
      check(out_err === 1'b0, "R9 reset out_err", {127'b0, out_err}, 0);
      check(out_data === '0, "R9 reset out_data", out_data, '0);
    end
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R9/R7 idle after reset",
          {126'b0, out_valid, in_ready}, 1);

    // R1-R4 at every size (R5 sizes 0,1,2)
    for (int sz = 0; sz < 3; sz++)
      for (int op = 0; op < 4; op++)
        send(rnd_vec(), rnd_vec(), op, sz, $sformatf("%s R5 size=%0d", nm[op], sz));

    // R6 illegal size code leaves data unchanged
    send(rnd_vec(), rnd_vec(), 0, 3, "R6 illegal size");
    send(rnd_vec(), rnd_vec(), 2, 1, "R5 legal after illegal");
    send(rnd_vec(), rnd_vec(), 3, 3, "R6 illegal size again");

    // R8 random stalls with back-to-back traffic
    stall_mode = 1;
    for (int i = 0; i < 40; i++) begin
      int op = $urandom() % 4;
      int sz = $urandom() % 4;
      send(rnd_vec(), rnd_vec(), op, sz,
           (sz == 3) ? "R6/R8 stalled illegal" : $sformatf("%s R8 stalled", nm[op]));
    end
    while (exp_data_q.size() != 0) @(negedge clk);
    stall_mode = 0;
    repeat (2) @(posedge clk);

    // R10 4x4 transpose of 32-bit lanes
    ra = {32'ha3, 32'ha2, 32'ha1, 32'ha0};
    rb = {32'hb3, 32'hb2, 32'hb1, 32'hb0};
    rc = {32'hc3, 32'hc2, 32'hc1, 32'hc0};
    rd = {32'hd3, 32'hd2, 32'hd1, 32'hd0};
    run_op(ra, rb, 2, 1, "R10 stage1 ab low", t0);
    run_op(ra, rb, 3, 1, "R10 stage1 ab high", t1);
    run_op(rc, rd, 2, 1, "R10 stage1 cd low", t2);
    run_op(rc, rd, 3, 1, "R10 stage1 cd high", t3);
    run_op(t0, t2, 2, 2, "R10 stage2 col0", c0);
    run_op(t0, t2, 3, 2, "R10 stage2 col1", c1);
    run_op(t1, t3, 2, 2, "R10 stage2 col2", c2);
    run_op(t1, t3, 3, 2, "R10 stage2 col3", c3);
    check(c0 === {32'hd0, 32'hc0, 32'hb0, 32'ha0}, "R10 column 0", c0, {32'hd0, 32'hc0, 32'hb0, 32'ha0});
    check(c1 === {32'hd1, 32'hc1, 32'hb1, 32'ha1}, "R10 column 1", c1, {32'hd1, 32'hc1, 32'hb1, 32'ha1});
    check(c2 === {32'hd2, 32'hc2, 32'hb2, 32'ha2}, "R10 column 2", c2, {32'hd2, 32'hc2, 32'hb2, 32'ha2});
    check(c3 === {32'hd3, 32'hc3, 32'hb3, 32'ha3}, "R10 column 3", c3, {32'hd3, 32'hc3, 32'hb3, 32'ha3});

    // R11 even+odd passes transpose each 2x2 block (16-bit lanes)
    ra = {16'h0107, 16'h0106, 16'h0105, 16'h0104, 16'h0103, 16'h0102, 16'h0101, 16'h0100};
    rb = {16'h0207, 16'h0206, 16'h0205, 16'h0204, 16'h0203, 16'h0202, 16'h0201, 16'h0200};
    run_op(ra, rb, 0, 0, "R11 even pass", ev);
    run_op(ra, rb, 1, 0, "R11 odd pass", od);
    check(ev === {16'h0206, 16'h0106, 16'h0204, 16'h0104, 16'h0202, 16'h0102, 16'h0200, 16'h0100},
          "R11 even half of 2x2 blocks", ev,
          {16'h0206, 16'h0106, 16'h0204, 16'h0104, 16'h0202, 16'h0102, 16'h0200, 16'h0100});
    check(od === {16'h0207, 16'h0107, 16'h0205, 16'h0105, 16'h0203, 16'h0103, 16'h0201, 16'h0101},
          "R11 odd half of 2x2 blocks", od,
          {16'h0207, 16'h0107, 16'h0205, 16'h0105, 16'h0203, 16'h0103, 16'h0201, 16'h0101});

    repeat (3) @(posedge clk);
    check(exp_data_q.size() == 0, "R7 scoreboard drained",
          VW'(exp_data_q.size()), '0);
    finish_run();
  end

endmodule